// File: doc/BRIEF.md
# Microcoded I2C Waveform Sequencer

This block produces the clock and data waveforms of an I2C bus from a program that the host writes into a 1024-entry step memory. Each entry sets the bus line levels for one step, says whether the step counts as active, says whether the data line is sampled at the end of the step, and names the entry that follows. A transaction is therefore a linked list of steps. Start and stop conditions, written bits, read bits and acknowledges are all built by the host out of these steps.

The host writes program words through a write port. Each word carries the index of the entry it fills. The host then sets the start bit in the control register and polls the running flag in the status word. When the run has finished it reads the sampled bits from a 32-bit read-data register. Both bus lines are driven open-drain: an output enable of 1 pulls the line low, and 0 releases it. Every step lasts `STEP_CYCLES` clock cycles. The default of 334 keeps the bus at or below 100 kHz with a 100 MHz clock, taking three steps per bit.

Top module: `i2c_wave_seq`

## Requirements
- R1: A program word writes entry `w[27:18]`. The entry takes its active flag from bit 13, its sample flag from bit 12, its SCL-low flag from bit 11, its SDA-low flag from bit 10, and its next index from `w[9:0]`.
- R2: A control write with bit 2 set while idle starts a run at entry 1. Status bit 7 reads 1 from the next cycle on.
- R3: While a run is on, every active entry holds its line levels on the outputs for exactly `STEP_CYCLES` cycles. The run then moves to the entry named by the next index.
- R4: A run ends at the first entry reached whose active flag is clear. One cycle later, status bit 7 reads 0 and the lines show that entry's levels, which then hold. Status bit 7 is high for N*`STEP_CYCLES`+1 cycles, where N is the number of active steps executed.
- R5: In a step with the sample flag set, the data-line input is captured at the last clock edge of the step. It is shifted into bit 0 of the read-data register while the older bits move up, so that only the last 32 samples are kept. A start clears the register.
- R6: `scl_oe_o` and `sda_oe_o` equal the SCL-low and SDA-low flags of the shown entry. A value of 1 pulls the line low and 0 releases it.
- R7: A control write without bit 2 has no effect. A start write during a run has no effect either: the waveform and the sampled data go on unchanged.
- R8: Reset releases both lines, clears status and clears the read-data register.
- R9: After a run, the read-data register holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Program word write strobe |
| prog_wdata_i | input | 32 | Program word (entry index and step fields) |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control word, bit 2 starts a run |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| status_o | output | 32 | Status word, bit 7 set while running |
| rdata_o | output | 32 | Sampled read bits, newest in bit 0 |

## Verification
Take the falling edge of the start write as cycle 0. Status bit 7 is due at cycle 0, and active step s shows its levels in cycles s*STEP+1 through (s+1)*STEP. The sample for step s is taken from the data line as it stands in cycle (s+1)*STEP-1. The run ends with status clear and the terminating entry's levels in cycle N*STEP+1. The bench walks its own copy of the program in lockstep with these cycle numbers. It compares the outputs at every falling edge and builds the expected read word from the line values it drove in exactly those sample cycles.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;
  localparam int unsigned IDX_W     = 10;
  localparam int unsigned DEPTH     = 1 << IDX_W;
  localparam int unsigned IDX_LSB   = 18;
  localparam int unsigned ACT_BIT   = 13;
  localparam int unsigned SMP_BIT   = 12;
  localparam int unsigned SCLN_BIT  = 11;
  localparam int unsigned SDAN_BIT  = 10;
  localparam int unsigned START_IDX = 1;
  localparam int unsigned GO_BIT    = 2;
  localparam int unsigned RUN_BIT   = 7;

  typedef struct packed {
    logic             act;
    logic             smp;
    logic             scl_n;
    logic             sda_n;
    logic [IDX_W-1:0] nxt;
  } step_t;

  function automatic step_t word_to_step(input logic [31:0] w);
    step_t s;
    s.act   = w[ACT_BIT];
    s.smp   = w[SMP_BIT];
    s.scl_n = w[SCLN_BIT];
    s.sda_n = w[SDAN_BIT];
    s.nxt   = w[IDX_W-1:0];
    return s;
  endfunction
endpackage

// File: rtl/i2c_seq_store.sv
`timescale 1ns/1ps
module i2c_seq_store
  import i2c_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output step_t            rstep_o
);
  step_t mem [DEPTH];
  logic [IDX_W-1:0] waddr;
  logic unused_wbits;

  assign waddr = wdata_i[IDX_LSB +: IDX_W];
  assign unused_wbits = ^{wdata_i[31:IDX_LSB+IDX_W], wdata_i[IDX_LSB-1:ACT_BIT+1]};

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr] <= word_to_step(wdata_i);
  end

  // combinational fetch: no extra cycle between steps
  assign rstep_o = mem[raddr_i];
endmodule

// File: rtl/i2c_seq_timer.sv
`timescale 1ns/1ps
module i2c_seq_timer #(
  parameter int unsigned STEP_CYCLES = 334
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(STEP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_seq_capture.sv
`timescale 1ns/1ps
module i2c_seq_capture #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_o <= '0;
    else if (clr_i) data_o <= '0;
    else if (en_i)  data_o <= {data_o[DATA_W-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_wave_seq.sv
`timescale 1ns/1ps
module i2c_wave_seq
  import i2c_seq_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 334,
  parameter int unsigned RDATA_W     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic [31:0]        prog_wdata_i,
  input  logic               ctrl_we_i,
  input  logic [31:0]        ctrl_wdata_i,
  input  logic               sda_i,
  output logic               scl_oe_o,
  output logic               sda_oe_o,
  output logic [31:0]        status_o,
  output logic [RDATA_W-1:0] rdata_o
);
  logic             run_q;
  logic [IDX_W-1:0] pc_q;
  logic             scl_low_q, sda_low_q;
  step_t            cur;
  logic             go, active, step_last;
  logic             unused_ctrl;

  assign unused_ctrl = ^{ctrl_wdata_i[31:GO_BIT+1], ctrl_wdata_i[GO_BIT-1:0]};

  assign go     = ctrl_we_i & ctrl_wdata_i[GO_BIT] & ~run_q;
  assign active = run_q & cur.act;

  i2c_seq_store u_store (
    .clk_i   (clk_i),
    .we_i    (prog_we_i),
    .wdata_i (prog_wdata_i),
    .raddr_i (pc_q),
    .rstep_o (cur)
  );

  i2c_seq_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go),
    .en_i   (active),
    .last_o (step_last)
  );

  i2c_seq_capture #(.DATA_W(RDATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go),
    .en_i   (active & step_last & cur.smp),
    .bit_i  (sda_i),
    .data_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      pc_q      <= '0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else if (go) begin
      run_q <= 1'b1;
      pc_q  <= IDX_W'(START_IDX);
    end else if (run_q) begin
      // lines follow the current entry, including the terminating one
      scl_low_q <= cur.scl_n;
      sda_low_q <= cur.sda_n;
      if (!cur.act)       run_q <= 1'b0;
      else if (step_last) pc_q  <= cur.nxt;
    end
  end

  assign scl_oe_o = scl_low_q;
  assign sda_oe_o = sda_low_q;

  always_comb begin
    status_o          = '0;
    status_o[RUN_BIT] = run_q;
  end
endmodule

// File: rtl/i2c_wave_seq_chk.sv
`timescale 1ns/1ps
module i2c_wave_seq_chk #(
  parameter int unsigned STEP_CYCLES = 334,
  parameter int unsigned RDATA_W     = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ctrl_go_i,
  input logic               busy_i,
  input logic               scl_oe_o,
  input logic               sda_oe_o,
  input logic [RDATA_W-1:0] rdata_o
);
  localparam int unsigned PW = $clog2(STEP_CYCLES + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(STEP_CYCLES - 1);

  logic [PW-1:0] ph_q;

  // phase within the current step, kept independently of the design's timer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ph_q <= '0;
    else if (ctrl_go_i && !busy_i) ph_q <= '0;
    else if (busy_i)              ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
  end

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_go_i && !busy_i |=> busy_i);

  p_no_spurious_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_go_i && !busy_i |=> !busy_i);

  p_lines_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && (ph_q != PW'(1)) |-> $stable({scl_oe_o, sda_oe_o}));

  p_clear_on_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_go_i && !busy_i |=> rdata_o == '0);

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_i) && !$past(ctrl_go_i) |-> $stable(rdata_o));
endmodule

bind i2c_wave_seq i2c_wave_seq_chk #(
  .STEP_CYCLES (STEP_CYCLES),
  .RDATA_W     (RDATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_go_i (ctrl_we_i & ctrl_wdata_i[2]),
  .busy_i    (status_o[7]),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .rdata_o   (rdata_o)
);

// File: tb/i2c_wave_seq_tb.sv
`timescale 1ns/1ps
module i2c_wave_seq_tb;
  localparam int STEP = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we = 1'b0;
  logic [31:0] prog_wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        slave_low = 1'b0;
  logic        sda_in;
  logic        scl_oe, sda_oe;
  logic [31:0] status, rdata;

  always #2.5 clk = ~clk;

  assign sda_in = ~sda_oe & ~slave_low;

  i2c_wave_seq #(.STEP_CYCLES(STEP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .prog_we_i(prog_we), .prog_wdata_i(prog_wdata),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .sda_i(sda_in), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .status_o(status), .rdata_o(rdata)
  );

  int vectors = 0, errors = 0;
  bit done = 0;
  bit m_act [1024];
  bit m_smp [1024];
  bit m_scln [1024];
  bit m_sdan [1024];
  int m_nxt [1024];
  int pa;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // levels given as line levels: 1 = released/high
  task automatic emit(input int idx, input bit act, input bit smp, input bit scl,
                      input bit sda, input int nxt);
    m_act[idx] = act; m_smp[idx] = smp; m_scln[idx] = !scl; m_sdan[idx] = !sda;
    m_nxt[idx] = nxt;
    @(negedge clk);
    prog_we = 1'b1;
    prog_wdata = (32'(idx) << 18) | (32'(act) << 13) | (32'(smp) << 12) |
                 (32'(!scl) << 11) | (32'(!sda) << 10) | 32'(nxt);
  endtask

  task automatic prog_done();
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic wbit(input bit d);
    emit(pa, 1, 0, 0, d, pa + 1);
    emit(pa + 1, 1, 0, 1, d, pa + 2);
    emit(pa + 2, 1, 0, 0, d, pa + 3);
    pa += 3;
  endtask

  task automatic rbit();
    emit(pa, 1, 0, 0, 1, pa + 1);
    emit(pa + 1, 1, 0, 1, 1, pa + 2);
    emit(pa + 2, 1, 1, 1, 1, pa + 3);
    emit(pa + 3, 1, 0, 0, 1, pa + 4);
    pa += 4;
  endtask

  task automatic wbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    wbit(1'b1);
  endtask

  task automatic rbyte(input bit last);
    for (int i = 0; i < 8; i++) rbit();
    wbit(last);
  endtask

  task automatic cond_start();
    emit(pa, 1, 0, 1, 1, pa + 1);
    emit(pa + 1, 1, 0, 1, 0, pa + 2);
    emit(pa + 2, 1, 0, 0, 0, pa + 3);
    pa += 3;
  endtask

  task automatic cond_stop();
    emit(pa, 1, 0, 0, 0, pa + 1);
    emit(pa + 1, 1, 0, 1, 0, pa + 2);
    emit(pa + 2, 1, 0, 1, 1, 0);
  endtask

  // start a run and walk the bench program in lockstep with the outputs
  task automatic run_check(input string tag, input bit poke);
    int pc, steps, wave_err;
    logic [31:0] exp;
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 32'h4;
    @(negedge clk);
    ctrl_we = 1'b0;
    chk({"R2 status after start ", tag}, status, 32'h80);
    pc = 1; steps = 0; wave_err = 0; exp = '0;
    while (m_act[pc] && steps < 4000) begin
      for (int c = 0; c < STEP; c++) begin
        if (poke && steps == 1 && c == 1) begin
          ctrl_we = 1'b1; ctrl_wdata = 32'h4;
        end
        @(negedge clk);
        ctrl_we = 1'b0;
        if (scl_oe !== m_scln[pc] || sda_oe !== m_sdan[pc] || status !== 32'h80) wave_err++;
        slave_low = 1'($urandom % 2);
        if (c == STEP - 2 && m_smp[pc]) exp = {exp[30:0], ~sda_oe & ~slave_low};
      end
      pc = m_nxt[pc];
      steps++;
    end
    @(negedge clk);
    chk({"R3 R6 waveform mismatches ", tag}, 32'(wave_err), 32'd0);
    chk({"R4 status at end ", tag}, status, 32'h0);
    chk({"R4 R6 terminating levels ", tag}, {30'b0, scl_oe, sda_oe}, {30'b0, m_scln[pc], m_sdan[pc]});
    chk({"R5 read data ", tag}, rdata, exp);
    repeat (5) @(negedge clk);
    chk({"R9 read data held ", tag}, rdata, exp);
  endtask

  task automatic xact(input string tag, input int nw, input int nr, input bit poke);
    logic [6:0] addr;
    addr = 7'($urandom);
    emit(0, 0, 0, 1, 1, 0);
    pa = 1;
    cond_start();
    wbyte({addr, 1'b0});
    for (int i = 0; i < nw; i++) wbyte(8'($urandom));
    if (nr > 0) begin
      cond_start();
      wbyte({addr, 1'b1});
      for (int i = 0; i < nr; i++) rbyte(i == nr - 1);
    end
    cond_stop();
    prog_done();
    run_check(tag, poke);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 status in reset", status, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 lines released after reset", {30'b0, scl_oe, sda_oe}, 32'h0);
    chk("R8 read data after reset", rdata, 32'h0);

    // control write without the start bit
    emit(0, 0, 0, 1, 1, 0);
    emit(1, 0, 0, 0, 1, 0);
    prog_done();
    ctrl_we = 1'b1; ctrl_wdata = 32'hFFFF_FFFB;
    @(negedge clk);
    ctrl_we = 1'b0;
    @(negedge clk);
    chk("R7 no start without bit 2", status, 32'h0);

    // first entry already inactive: one busy cycle, SCL pulled low
    run_check("immediate end", 0);

    xact("write only", 2, 0, 0);
    xact("read two", 1, 2, 0);
    xact("read five keeps last 32", 0, 5, 0);
    xact("start during run", 1, 1, 1);

    // raw program with random fields
    for (int t = 0; t < 4; t++) begin
      int len;
      len = 1 + int'($urandom % 40);
      emit(0, 0, 0, 1, 1, 0);
      for (int i = 0; i < len; i++)
        emit(1 + i, 1, 1'($urandom), 1'($urandom), 1'($urandom), 2 + i);
      emit(1 + len, 0, 0, 1'($urandom), 1'($urandom), 0);
      prog_done();
      run_check("R1 raw fields", 0);
    end

    for (int t = 0; t < 8; t++)
      xact("random transaction", int'($urandom % 3), int'($urandom % 6), 1'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule